// File: doc/BRIEF.md
# Leveled Priority Interrupt Controller

This block collects thirteen level-sensitive interrupt requests, numbered 1 to 13, and turns them into a single request toward the processor. That request has two parts: a 3-bit interrupt level and an 8-bit vector. Each source has its own 8-bit control register. The low five bits of that register form a ranking key. Key bits [4:2] give the level the processor sees, and key bits [1:0] give a priority that orders sources within one level. A source takes part only while its pending bit is set and its mask bit is clear.

Software uses a small register port with a one-cycle write and a combinational read. Through it, software programs the control registers, the mask register and the per-source vector registers, and reads back the pending bits. In the default configuration, sources 12 and 13 (the two serial ports) return a vector that software has programmed. Every other source is autovectored: its vector is 24 plus its level. The timers are wired to sources 9 and 10.

The arbitration result is held in registers. A change on a request input, or a register write, shows up on the outputs two clock edges later.

Top module: `prio_intc`

## Requirements
- R1: After reset the mask register (address 0x10) reads 0x3FFE, so every source is masked. Every control register (addresses 0x01 to 0x0D, source n at address n) reads 0, and `cpu_level` is 0.
- R2: The pending register (address 0x11) has bit n for source n, and bit 0 always reads 0. Each bit copies `irq_in[n]` at every clock edge. Writes to address 0x11 are ignored.
- R3: A mask bit of 1 (bit n of address 0x10 for source n) removes that source from arbitration.
- R4: Among unmasked pending sources, the winner is the one with the largest control bits [4:0]. A source whose key is 0 never wins.
- R5: When two or more sources share the largest key, the lowest-numbered source wins.
- R6: `cpu_level` equals control bits [4:2] of the winner.
- R7: When no source can win, `cpu_level` is 0.
- R8: When the winner is autovectored, `cpu_vector` is 24 plus `cpu_level`.
- R9: Sources 12 and 13 each have an 8-bit vector register at address 0x20+n. That register resets to 0x0F and reads back what was written. When one of these sources wins, `cpu_vector` equals its vector register. Vector addresses of autovectored sources read 0.
- R10: A register write or a request change reaches `cpu_level` and `cpu_vector` at the second rising clock edge after it is applied. The first edge does not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 13 | Level request per source, bit n for source n (bits [13:1]) |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| cpu_level | output | 3 | Interrupt level toward the processor, 0 when idle |
| cpu_vector | output | 8 | Vector of the winning source |

## Verification
Directed cases set one key above another to show that the larger key wins. Equal keys on sources 4 and 9, and then on sources 5 and 12, show that the lower number wins. Masking the lower source of a tie hands the win to the other source; with source 12 this also moves the vector from the autovector to the programmed value. A write followed by sampling after one edge and again after two edges separates the correct latency from an off-by-one. A long seeded random run draws request, mask and key patterns with many equal keys, so ties, masked winners and level-0 keys occur often, and compares level and vector against a bench model.

// File: rtl/prio_intc_pkg.sv
// Shared register decode for the priority interrupt controller.
// Assumes a 6-bit register address whose bits [5:4] pick the register class
// and whose bits [3:0] pick the source (1..15) or the mask/pending word.
package prio_intc_pkg;

    localparam int ADDR_W = 6;
    localparam int IDX_W  = 4;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_CTRL,
        RK_MASK,
        RK_PEND,
        RK_VEC
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e          kind;
        logic [IDX_W-1:0]   idx;
    } reg_sel_t;

    // Map an address onto a register class and source index.
    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        s.idx = a[IDX_W-1:0];
        case (a[ADDR_W-1:IDX_W])
            2'b00:   s.kind = RK_CTRL;
            2'b01:   s.kind = (a[IDX_W-1:0] == 4'h0) ? RK_MASK :
                              (a[IDX_W-1:0] == 4'h1) ? RK_PEND : RK_NONE;
            2'b10:   s.kind = RK_VEC;
            default: s.kind = RK_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/prio_intc_pend.sv
// Pending capture: one flop per source that follows the request level.
// Assumes requests are already synchronous to clk. Bit 0 is unused and held 0.
module prio_intc_pend #(
    parameter int NUM_SRC = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC:1]   irq_in,
    output logic [NUM_SRC:0]   pend_q
);

    // Sample every request level on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= {irq_in, 1'b0};
    end

    assert_pend_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend_q == {$past(irq_in), 1'b0}));

endmodule

// File: rtl/prio_intc_regs.sv
// Register file: per-source control bytes, the mask word and the
// programmable vector bytes of the sources selected by PROG_VEC.
// Assumes NUM_SRC <= 15 and DATA_W > NUM_SRC. Reads are combinational.
module prio_intc_regs
    import prio_intc_pkg::*;
#(
    parameter int              NUM_SRC  = 13,
    parameter int              DATA_W   = 16,
    parameter int              CTRL_W   = 8,
    parameter int              VEC_W    = 8,
    parameter logic [15:0]     PROG_VEC = 16'h3000,
    parameter logic [VEC_W-1:0] VEC_RST = 8'h0F
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [DATA_W-1:0]               wdata,
    input  logic [NUM_SRC:0]                pend_q,
    output logic [DATA_W-1:0]               rdata,
    output logic [NUM_SRC:0]                mask_q,
    output logic [NUM_SRC:1][CTRL_W-1:0]    ctrl_q,
    output logic [NUM_SRC:1][VEC_W-1:0]     vec_q
);

    localparam logic [NUM_SRC:0] MASK_RST = {{NUM_SRC{1'b1}}, 1'b0};

    reg_sel_t sel;
    logic     idx_ok;

    // Decode the address once for writes and reads.
    always_comb begin
        sel    = decode_addr(addr);
        idx_ok = (sel.idx != '0) && (int'(sel.idx) <= NUM_SRC);
    end

    // Mask word; a set bit blocks the source.
    always_ff @(posedge clk) begin
        if (!rst_n)                       mask_q <= MASK_RST;
        else if (wr && sel.kind == RK_MASK) mask_q <= {wdata[NUM_SRC:1], 1'b0};
    end

    for (genvar i = 1; i <= NUM_SRC; i++) begin : g_src
        // Control byte of source i.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctrl_q[i] <= '0;
            else if (wr && sel.kind == RK_CTRL && sel.idx == IDX_W'(i))
                ctrl_q[i] <= wdata[CTRL_W-1:0];
        end

        if (PROG_VEC[i]) begin : g_prog
            // Programmable vector byte of source i.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    vec_q[i] <= VEC_RST;
                else if (wr && sel.kind == RK_VEC && sel.idx == IDX_W'(i))
                    vec_q[i] <= wdata[VEC_W-1:0];
            end
        end else begin : g_auto
            assign vec_q[i] = '0;
        end
    end

    // Read-back multiplexer.
    always_comb begin
        rdata = '0;
        case (sel.kind)
            RK_CTRL: if (idx_ok) rdata[CTRL_W-1:0] = ctrl_q[sel.idx];
            RK_MASK: rdata[NUM_SRC:0] = mask_q;
            RK_PEND: rdata[NUM_SRC:0] = pend_q;
            RK_VEC:  if (idx_ok) rdata[VEC_W-1:0] = vec_q[sel.idx];
            default: rdata = '0;
        endcase
    end

    assert_mask_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask_q == MASK_RST));

endmodule

// File: rtl/prio_intc_arb.sv
// Arbiter: scans sources upward and keeps the first source holding the
// largest nonzero key; forms the level and vector of that source.
// Assumes keys are the low LVL_W+PRI_W bits of each control byte.
module prio_intc_arb #(
    parameter int              NUM_SRC      = 13,
    parameter int              CTRL_W       = 8,
    parameter int              VEC_W        = 8,
    parameter int              LVL_W        = 3,
    parameter int              PRI_W        = 2,
    parameter int              SRC_W        = 4,
    parameter int              AUTOVEC_BASE = 24,
    parameter logic [15:0]     PROG_VEC     = 16'h3000
) (
    input  logic [NUM_SRC:0]                pend_q,
    input  logic [NUM_SRC:0]                mask_q,
    input  logic [NUM_SRC:1][CTRL_W-1:0]    ctrl_q,
    input  logic [NUM_SRC:1][VEC_W-1:0]     vec_q,
    output logic [SRC_W-1:0]                win_id,
    output logic [LVL_W-1:0]                level,
    output logic [VEC_W-1:0]                vector
);

    localparam int KEY_W = LVL_W + PRI_W;

    logic [NUM_SRC:0]  active;
    logic [KEY_W-1:0]  best_key;

    // Strictly-greater upward scan: equal keys keep the lower source.
    always_comb begin
        active   = pend_q & ~mask_q;
        best_key = '0;
        win_id   = '0;
        for (int i = 1; i <= NUM_SRC; i++) begin
            if (active[i] && (ctrl_q[i][KEY_W-1:0] > best_key)) begin
                best_key = ctrl_q[i][KEY_W-1:0];
                win_id   = SRC_W'(i);
            end
        end
    end

    // Level and vector of the winner.
    always_comb begin
        level = best_key[KEY_W-1:PRI_W];
        if (win_id == '0)
            vector = '0;
        else if (PROG_VEC[win_id])
            vector = vec_q[win_id];
        else
            vector = VEC_W'(AUTOVEC_BASE) + VEC_W'(level);
    end

endmodule

// File: rtl/prio_intc.sv
// Top of the priority interrupt controller: pending capture, register
// file, arbiter and the output register stage.
// Assumes synchronous requests; outputs lag inputs and writes by two edges.
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int              NUM_SRC      = 13,
    parameter int              DATA_W       = 16,
    parameter int              CTRL_W       = 8,
    parameter int              VEC_W        = 8,
    parameter int              LVL_W        = 3,
    parameter int              PRI_W        = 2,
    parameter int              AUTOVEC_BASE = 24,
    parameter logic [15:0]     PROG_VEC     = 16'h3000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC:1]     irq_in,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic [LVL_W-1:0]     cpu_level,
    output logic [VEC_W-1:0]     cpu_vector
);

    localparam int SRC_W = $clog2(NUM_SRC + 1);
    localparam int KEY_W = LVL_W + PRI_W;

    logic [NUM_SRC:0]             pend_q;
    logic [NUM_SRC:0]             mask_q;
    logic [NUM_SRC:1][CTRL_W-1:0] ctrl_q;
    logic [NUM_SRC:1][VEC_W-1:0]  vec_q;
    logic [SRC_W-1:0]             win_nxt;
    logic [SRC_W-1:0]             win_q;
    logic [LVL_W-1:0]             lvl_nxt;
    logic [VEC_W-1:0]             vec_nxt;

    prio_intc_pend #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_in (irq_in),
        .pend_q (pend_q)
    );

    prio_intc_regs #(
        .NUM_SRC  (NUM_SRC),
        .DATA_W   (DATA_W),
        .CTRL_W   (CTRL_W),
        .VEC_W    (VEC_W),
        .PROG_VEC (PROG_VEC)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .pend_q (pend_q),
        .rdata  (reg_rdata),
        .mask_q (mask_q),
        .ctrl_q (ctrl_q),
        .vec_q  (vec_q)
    );

    prio_intc_arb #(
        .NUM_SRC      (NUM_SRC),
        .CTRL_W       (CTRL_W),
        .VEC_W        (VEC_W),
        .LVL_W        (LVL_W),
        .PRI_W        (PRI_W),
        .SRC_W        (SRC_W),
        .AUTOVEC_BASE (AUTOVEC_BASE),
        .PROG_VEC     (PROG_VEC)
    ) u_arb (
        .pend_q (pend_q),
        .mask_q (mask_q),
        .ctrl_q (ctrl_q),
        .vec_q  (vec_q),
        .win_id (win_nxt),
        .level  (lvl_nxt),
        .vector (vec_nxt)
    );

    // Register the arbitration result toward the processor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q      <= '0;
            cpu_level  <= '0;
            cpu_vector <= '0;
        end else begin
            win_q      <= win_nxt;
            cpu_level  <= lvl_nxt;
            cpu_vector <= vec_nxt;
        end
    end

    assert_win_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_nxt != '0) |-> (!mask_q[win_nxt] && pend_q[win_nxt]));

    assert_level_from_ctrl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_nxt != '0) |=> (cpu_level == $past(ctrl_q[win_nxt][KEY_W-1:PRI_W])));

    assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (~|(pend_q & ~mask_q)) |=> (cpu_level == '0));

    assert_autovec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((win_q != '0) && !PROG_VEC[win_q]) |->
            (cpu_vector == VEC_W'(AUTOVEC_BASE) + VEC_W'(cpu_level)));

endmodule

// File: tb/prio_intc_bench.sv
module prio_intc_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:1] irq_in = '0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [2:0]  cpu_level;
    logic [7:0]  cpu_vector;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Bench model of the programmed state.
    logic [7:0]  m_ctrl [1:13];
    logic [7:0]  m_vec  [12:13];
    logic [13:1] m_mask;

    always #4 clk = ~clk;

    prio_intc u_prio_intc (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .cpu_level  (cpu_level),
        .cpu_vector (cpu_vector)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One write: drive after a falling edge, captured at the next rising edge.
    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a >= 6'h01 && a <= 6'h0D) m_ctrl[a] = d[7:0];
        if (a == 6'h10) m_mask = d[13:1];
        if (a == 6'h2C || a == 6'h2D) m_vec[a - 6'h20] = d[7:0];
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic int exp_win();
        int w = 0;
        int best = 0;
        for (int i = 1; i <= 13; i++)
            if (irq_in[i] && !m_mask[i] && int'(m_ctrl[i][4:0]) > best) begin
                best = int'(m_ctrl[i][4:0]);
                w = i;
            end
        return w;
    endfunction

    function automatic int exp_level();
        int w = exp_win();
        return (w == 0) ? 0 : int'(m_ctrl[w][4:2]);
    endfunction

    function automatic int exp_vector();
        int w = exp_win();
        if (w == 12 || w == 13) return int'(m_vec[w]);
        return 24 + exp_level();
    endfunction

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R10: watchdog actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        void'($urandom(32'h5EED1234));
        for (int i = 1; i <= 13; i++) m_ctrl[i] = 8'h00;
        m_vec[12] = 8'h0F; m_vec[13] = 8'h0F;
        m_mask = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(6'h10, d); chk("R1 mask reset", d, 16'h3FFE);
        rd(6'h05, d); chk("R1 ctrl reset", d, 0);
        chk("R1 level reset", cpu_level, 0);
        rd(6'h2C, d); chk("R9 vector reset", d, 8'h0F);

        // R2 pending follows input, writes ignored
        irq_in = 13'h0A55;
        @(negedge clk);
        rd(6'h11, d); chk("R2 pending follow", d, {2'b00, 13'h0A55, 1'b0});
        wr(6'h11, 16'h0000);
        rd(6'h11, d); chk("R2 pending write ignored", d, {2'b00, 13'h0A55, 1'b0});
        irq_in = '0;
        @(negedge clk);
        rd(6'h11, d); chk("R2 pending clears", d, 0);

        // R4 larger key wins; still masked so level 0 first (R3)
        wr(6'h03, 16'h001C);
        wr(6'h07, 16'h001D);
        irq_in[3] = 1'b1; irq_in[7] = 1'b1;
        settle();
        chk("R3 all masked level", cpu_level, 0);
        wr(6'h10, 16'h0000);
        settle();
        chk("R4 larger key level", cpu_level, 7);
        chk("R8 autovector", cpu_vector, 31);

        // R5 tie goes to lower source, R3 mask hands it over
        irq_in = '0; irq_in[4] = 1'b1; irq_in[9] = 1'b1;
        wr(6'h04, 16'h000E);
        wr(6'h09, 16'h000E);
        settle();
        chk("R5 tie level", cpu_level, 3);
        chk("R5 tie vector", cpu_vector, 27);
        irq_in = '0; irq_in[5] = 1'b1; irq_in[12] = 1'b1;
        wr(6'h05, 16'h0011);
        wr(6'h0C, 16'h0011);
        wr(6'h2C, 16'h0040);
        settle();
        chk("R5 tie lower wins vector", cpu_vector, 28);
        rd(6'h2C, d); chk("R9 vector readback", d, 16'h0040);
        rd(6'h23, d); chk("R9 autovector source reads 0", d, 0);
        wr(6'h10, 16'h0020);
        settle();
        chk("R3 masked lower, R9 programmed vector", cpu_vector, 8'h40);
        chk("R6 level of source 12", cpu_level, 4);

        // R10 latency on a write
        wr(6'h0C, 16'h0018);
        chk("R10 no change after one edge", cpu_level, 4);
        @(negedge clk);
        chk("R10 change after two edges", cpu_level, 6);

        // R7 and key zero never wins
        wr(6'h0C, 16'h0000);
        settle();
        chk("R7 zero key idle", cpu_level, 0);
        irq_in = '0;
        settle();
        chk("R7 no request idle", cpu_level, 0);

        // Random phase
        for (int it = 0; it < 400; it++) begin
            irq_in = 13'($urandom);
            wr(6'h10, 16'($urandom & $urandom) & 16'h3FFE);
            if ($urandom % 2 == 0) wr(6'($urandom_range(1, 13)), 16'($urandom));
            if ($urandom % 5 == 0) wr(6'($urandom_range(12, 13) + 32), 16'($urandom));
            settle();
            chk("R6 random level", cpu_level, exp_level());
            if (exp_win() != 0) chk("R8/R9 random vector", cpu_vector, exp_vector());
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule